// File: doc/BRIEF.md
# Packed High-Half Interleave Unit

This block is a one-stage pipelined vector permute unit for 128-bit operands. It discards the lower half of each of two source vectors and weaves the upper halves together, element by element, at a granularity of 8, 16, 32 or 64 bits. The first source supplies the even-numbered elements of the result and the second source the odd-numbered ones. If the second source is zero, the unit widens each upper element of the first source to twice its size with zero fill. This is the usual first step in raising unsigned precision before arithmetic.

The element size comes from one of two places. In direct mode, a two-bit size input sets it. In opcode mode, an instruction opcode byte is decoded to set it, and an opcode the unit does not know is reported as illegal. The result is registered one cycle after the request. The unit keeps no status flags.

Top module: `vec_hi_weave`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `out_valid`, `illegal` and `result` to zero on that edge.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. On a cycle where `in_valid` is low, `result` keeps its previous value and `illegal` is 0 on the following cycle.
- R3: When `use_opcode` is 0, the element width comes from `size_sel`: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. `op_byte` has no effect in this mode, and `illegal` stays 0.
- R4: When `use_opcode` is 1, `op_byte` sets the width: 0x68 gives 8 bits, 0x69 gives 16, 0x6A gives 32 and 0x6D gives 64. `size_sel` has no effect in this mode.
- R5: Bits 63:0 of both `src_a` and `src_b` never affect `result`.
- R6: Byte width: result byte 2i equals `src_a` byte 8+i, and result byte 2i+1 equals `src_b` byte 8+i, for i from 0 to 7.
- R7: 16-bit and 32-bit widths: result element 2i equals upper-half element i of `src_a`, and result element 2i+1 equals upper-half element i of `src_b`. That gives four pairs for 16 bits and two pairs for 32 bits.
- R8: 64-bit width: `result` equals `src_b[127:64]` placed above `src_a[127:64]`.
- R9: When `src_b` is all zeros, each upper element of `src_a` appears in the result zero-extended to twice its width, at every element width.
- R10: In opcode mode, any opcode other than the four listed in R4 makes `illegal` 1 and `result` all zeros on the output cycle. A legal request leaves `illegal` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| use_opcode | input | 1 | 1: take the width from `op_byte`; 0: take it from `size_sel` |
| size_sel | input | 2 | Direct width code (0=8, 1=16, 2=32, 3=64 bits) |
| op_byte | input | 8 | Opcode byte decoded in opcode mode |
| src_a | input | 128 | First source; its upper elements fill the even result positions |
| src_b | input | 128 | Second source; its upper elements fill the odd result positions |
| out_valid | output | 1 | The result of the request from the previous cycle is present |
| result | output | 128 | Registered interleaved result |
| illegal | output | 1 | The previous request carried an unknown opcode |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle valid latency and the clearing done by reset;
- that `result` holds while no request is present;
- that an illegal flag always comes with a valid, all-zero result, and that direct mode never raises it;
- the 64-bit placement;
- byte-width zero extension against the sampled inputs.

Other behaviour only the bench's directed scenarios can show, because it depends on chosen data:
- the full lane mapping at each width against an independent bit-level model;
- that the lower halves and the unused select input have no effect;
- the opcode-to-width mapping;
- zero extension at the wider sizes.

// File: rtl/vec_hi_weave_pkg.sv
package vec_hi_weave_pkg;

  // element width codes; the numeric value is the log2 of (width / 8)
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam int NUM_SIZES   = 4;
  localparam int BASE_ELEM_W = 8;

  // opcode bytes recognised in opcode mode
  localparam logic [7:0] OPC_WEAVE_8  = 8'h68;
  localparam logic [7:0] OPC_WEAVE_16 = 8'h69;
  localparam logic [7:0] OPC_WEAVE_32 = 8'h6A;
  localparam logic [7:0] OPC_WEAVE_64 = 8'h6D;

endpackage

// File: rtl/weave_size_decode.sv
module weave_size_decode
  import vec_hi_weave_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            use_opcode,
  input  logic [1:0]      size_sel,
  input  logic [OP_W-1:0] op_byte,
  output esz_e            esz,
  output logic            legal
);

  esz_e op_esz;
  logic op_known;

  always_comb begin
    op_esz   = ESZ_8;
    op_known = 1'b1;
    case (op_byte)
      OPC_WEAVE_8:  op_esz = ESZ_8;
      OPC_WEAVE_16: op_esz = ESZ_16;
      OPC_WEAVE_32: op_esz = ESZ_32;
      OPC_WEAVE_64: op_esz = ESZ_64;
      default:      op_known = 1'b0;
    endcase
  end

  // direct mode is always legal; opcode mode depends on the byte
  always_comb begin
    if (use_opcode) begin
      esz   = op_esz;
      legal = op_known;
    end else begin
      esz   = esz_e'(size_sel);
      legal = 1'b1;
    end
  end

endmodule

// File: rtl/weave_lane.sv
module weave_lane #(
  parameter int HALF_W = 64,
  parameter int ELEM_W = 8
) (
  input  logic [HALF_W-1:0]   hi_a,
  input  logic [HALF_W-1:0]   hi_b,
  output logic [2*HALF_W-1:0] woven
);

  localparam int N_ELEM = HALF_W / ELEM_W;

  // pair i: element from hi_a goes low, element from hi_b goes high
  for (genvar i = 0; i < N_ELEM; i++) begin : g_pair
    assign woven[(2*i)*ELEM_W   +: ELEM_W] = hi_a[i*ELEM_W +: ELEM_W];
    assign woven[(2*i+1)*ELEM_W +: ELEM_W] = hi_b[i*ELEM_W +: ELEM_W];
  end

endmodule

// File: rtl/weave_out_stage.sv
module weave_out_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         legal,
  input  logic [W-1:0] next_result,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         illegal
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & ~legal;
      if (in_valid) begin
        result <= next_result;
      end
    end
  end

endmodule

// File: rtl/vec_hi_weave.sv
module vec_hi_weave
  import vec_hi_weave_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              use_opcode,
  input  logic [1:0]        size_sel,
  input  logic [OP_W-1:0]   op_byte,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  localparam int HALF_W = DATA_W / 2;

  esz_e              esz;
  logic              legal;
  logic [DATA_W-1:0] cand [NUM_SIZES];
  logic [DATA_W-1:0] next_result;

  weave_size_decode #(.OP_W(OP_W)) u_dec (
    .use_opcode (use_opcode),
    .size_sel   (size_sel),
    .op_byte    (op_byte),
    .esz        (esz),
    .legal      (legal)
  );

  // one fixed wiring network per element width
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
    weave_lane #(
      .HALF_W (HALF_W),
      .ELEM_W (BASE_ELEM_W << g)
    ) u_lane (
      .hi_a  (src_a[DATA_W-1:HALF_W]),
      .hi_b  (src_b[DATA_W-1:HALF_W]),
      .woven (cand[g])
    );
  end

  always_comb begin
    next_result = legal ? cand[esz] : '0;
  end

  weave_out_stage #(.W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .legal       (legal),
    .next_result (next_result),
    .out_valid   (out_valid),
    .result      (result),
    .illegal     (illegal)
  );

endmodule

// File: rtl/vec_hi_weave_chk.sv
module vec_hi_weave_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              use_opcode,
  input logic [1:0]        size_sel,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);

  localparam int HALF_W = DATA_W / 2;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !illegal && result == '0));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !illegal && $stable(result)));

  p_direct_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_opcode) |=> !illegal);

  p_quad_place_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_opcode && size_sel == 2'd3) |=>
      result == {$past(src_b[DATA_W-1:HALF_W]), $past(src_a[DATA_W-1:HALF_W])});

  p_byte_zext_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_opcode && size_sel == 2'd0 && src_b == '0) |=>
      result[15:0] == {8'h00, $past(src_a[HALF_W+7:HALF_W])});

  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (out_valid && result == '0));

endmodule

bind vec_hi_weave vec_hi_weave_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .use_opcode (use_opcode),
  .size_sel   (size_sel),
  .src_a      (src_a),
  .src_b      (src_b),
  .out_valid  (out_valid),
  .result     (result),
  .illegal    (illegal)
);

// File: tb/test_vec_hi_weave.sv
`timescale 1ns/1ps
module test_vec_hi_weave;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         use_opcode;
  logic [1:0]   size_sel;
  logic [7:0]   op_byte;
  logic [127:0] src_a;
  logic [127:0] src_b;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  vec_hi_weave i_vec_hi_weave (
    .clk(clk), .rst(rst), .in_valid(in_valid), .use_opcode(use_opcode),
    .size_sel(size_sel), .op_byte(op_byte), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      n_fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  // bit-level model: result bit k comes from upper-half element (j/2) of a or b
  function automatic logic [127:0] ref_weave(input logic [127:0] a, input logic [127:0] b,
                                             input int ew);
    logic [127:0] r;
    r = '0;
    for (int k = 0; k < 128; k++) begin
      int j;
      int sb;
      j  = k / ew;
      sb = 64 + (j / 2) * ew + (k % ew);
      r[k] = (j % 2 == 1) ? b[sb] : a[sb];
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_zext(input logic [127:0] a, input int ew);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 64 / ew; i++) begin
      for (int t = 0; t < ew; t++) r[2*ew*i + t] = a[64 + ew*i + t];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // drive one request at a falling edge, sample outputs at the next falling edge
  task automatic issue(input logic v, input logic uo, input logic [1:0] sz,
                       input logic [7:0] op, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = v; use_opcode = uo; size_sel = sz; op_byte = op; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; use_opcode = 1'b0; size_sel = 2'd3;
    src_a = '1; src_b = '1; op_byte = 8'h00;
    @(negedge clk);
    @(negedge clk);
    check("R1", "out_valid after reset", 128'(out_valid), 128'd0);
    check("R1", "result after reset", result, '0);
    check("R1", "illegal after reset", 128'(illegal), 128'd0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_direct_sizes();
    for (int s = 0; s < 4; s++) begin
      logic [127:0] a;
      logic [127:0] b;
      a = rnd128(); b = rnd128();
      issue(1'b1, 1'b0, 2'(s), 8'h00, a, b);
      check("R2", "out_valid one cycle later", 128'(out_valid), 128'd1);
      if (s == 0)      check("R6", "byte weave", result, ref_weave(a, b, 8));
      else if (s == 3) check("R8", "quad weave", result, {b[127:64], a[127:64]});
      else             check("R7", "word/dword weave", result, ref_weave(a, b, 8 << s));
      check("R3", "direct mode not illegal", 128'(illegal), 128'd0);
    end
    issue(1'b1, 1'b0, 2'd0, 8'h00, 128'h0f0e0d0c0b0a09080706050403020100,
          128'hfffefdfcfbfaf9f8f7f6f5f4f3f2f1f0);
    check("R6", "byte weave fixed pattern", result, 128'hff0ffe0efd0dfc0cfb0bfa0af909f808);
  endtask

  task automatic t_direct_ignores_op();
    logic [127:0] a;
    logic [127:0] b;
    a = rnd128(); b = rnd128();
    issue(1'b1, 1'b0, 2'd1, 8'h6D, a, b);
    check("R3", "op_byte ignored in direct mode", result, ref_weave(a, b, 16));
    issue(1'b1, 1'b0, 2'd2, 8'hFF, a, b);
    check("R3", "unknown op ignored in direct mode", result, ref_weave(a, b, 32));
    check("R3", "no illegal in direct mode", 128'(illegal), 128'd0);
  endtask

  task automatic t_opcode_decode();
    logic [7:0] ops [4];
    ops[0] = 8'h68; ops[1] = 8'h69; ops[2] = 8'h6A; ops[3] = 8'h6D;
    for (int s = 0; s < 4; s++) begin
      logic [127:0] a;
      logic [127:0] b;
      a = rnd128(); b = rnd128();
      // size_sel set to a mismatching code to show it is ignored
      issue(1'b1, 1'b1, 2'(3 - s), ops[s], a, b);
      check("R4", "opcode selects width", result, ref_weave(a, b, 8 << s));
      check("R10", "legal opcode not flagged", 128'(illegal), 128'd0);
    end
  endtask

  task automatic t_low_ignored();
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] first;
    a = rnd128(); b = rnd128();
    issue(1'b1, 1'b0, 2'd0, 8'h00, a, b);
    first = result;
    issue(1'b1, 1'b0, 2'd0, 8'h00, {a[127:64], ~a[63:0]}, {b[127:64], ~b[63:0]});
    check("R5", "lower halves ignored (byte)", result, first);
    issue(1'b1, 1'b1, 2'd0, 8'h6A, {a[127:64], 64'd0}, {b[127:64], 64'hFFFF_FFFF_FFFF_FFFF});
    check("R5", "lower halves ignored (dword)", result, ref_weave(a, b, 32));
  endtask

  task automatic t_zero_ext();
    for (int s = 0; s < 4; s++) begin
      logic [127:0] a;
      a = rnd128();
      issue(1'b1, 1'b0, 2'(s), 8'h00, a, '0);
      check("R9", "zero second source widens", result, ref_zext(a, 8 << s));
    end
  endtask

  task automatic t_illegal();
    logic [127:0] a;
    a = rnd128();
    issue(1'b1, 1'b1, 2'd0, 8'h6B, a, '1);
    check("R10", "unknown opcode flagged", 128'(illegal), 128'd1);
    check("R10", "unknown opcode zero result", result, '0);
    check("R10", "unknown opcode still valid", 128'(out_valid), 128'd1);
    issue(1'b1, 1'b1, 2'd0, 8'h68, a, '1);
    check("R10", "flag clears on legal opcode", 128'(illegal), 128'd0);
  endtask

  task automatic t_hold();
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] kept;
    a = rnd128(); b = rnd128();
    issue(1'b1, 1'b0, 2'd2, 8'h00, a, b);
    kept = result;
    issue(1'b0, 1'b1, 2'd0, 8'h77, ~a, ~b);
    check("R2", "no valid without request", 128'(out_valid), 128'd0);
    check("R2", "result held without request", result, kept);
    check("R2", "illegal low without request", 128'(illegal), 128'd0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; use_opcode = 1'b0; size_sel = 2'd0;
    op_byte = 8'h00; src_a = '0; src_b = '0;
    t_reset();
    t_direct_sizes();
    t_direct_ignores_op();
    t_opcode_decode();
    t_low_ignored();
    t_zero_ext();
    t_illegal();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule